// File: doc/BRIEF.md
# Peripheral Enable Clock and Valid-Address Strobe Generator

This block sits on an accelerator board whose processor runs on its own fast clock while the host bus keeps its original, slower clock. Slow peripherals on the host bus need an enable clock with a fixed period. They also need a valid-address strobe that is aligned to that enable clock. Both are rebuilt here from the host bus clock alone. Peripheral timing therefore stays inside its limits whatever frequency the processor runs at.

A free-running phase counter produces the enable clock `e_clk`. E is low for the first part of each period and high for the rest, and it runs whether or not any transfer is in progress. The processor-side address strobe `as_n` and the slow-device request `vpa_n` pass through an input register stage. When both are seen low together, a transfer is accepted. The controller then waits for the next start of an E-low phase and asserts `vma_n`. It holds `vma_n` through one whole E period. At the falling edge of E that closes that period it releases `vma_n` and pulses `cyc_done` for one clock, which tells the processor side that the transfer is complete.

Slow-device reads and writes use the same handshake as autovectored interrupt acknowledge cycles. If the address strobe negates before the strobe is issued, the request is dropped. Once a transfer has finished, no new one starts until the address strobe has been seen negated. The slow device has therefore released the bus before the next cycle begins.

Top module: `periph_eclk_gen`

## Requirements
- R1: After the k-th rising clock edge following reset release, `e_clk` is 1 exactly when (k mod E_PERIOD) >= E_PERIOD-E_HIGH. With the defaults of 10 and 4, E is low for 6 clocks and then high for 4.
- R2: `e_clk` keeps toggling with no bus activity, giving one rising edge every E_PERIOD clocks.
- R3: A transfer is accepted only when `as_n` = 0 and `vpa_n` = 0 are sampled together. `vpa_n` low with `as_n` high starts nothing, and neither does `as_n` low with `vpa_n` high.
- R4: Inputs applied after edge k are seen by the controller at edge k+1+REQ_STAGES. `vma_n` goes low at the first edge m at or after that edge for which m mod E_PERIOD = 0. That edge is the falling edge of E.
- R5: `vma_n` stays low for exactly E_PERIOD clocks and rises at edge m+E_PERIOD, which is again a falling edge of E. `cyc_done` is 1 for the single clock after that same edge.
- R6: If `as_n` is sampled high before `vma_n` has been asserted, the request is abandoned. Neither `vma_n` nor `cyc_done` is then asserted.
- R7: Negating `as_n` while `vma_n` is low neither shortens nor cancels the transfer.
- R8: After `cyc_done`, no new transfer starts while `as_n` stays low, even if `vpa_n` stays low too. A new transfer is accepted once `as_n` has been seen high.
- R9: While `rst` is 1, `e_clk` = 0, `vma_n` = 1 and `cyc_done` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host system bus clock |
| rst | input | 1 | Asynchronous reset, active high |
| as_n | input | 1 | Processor-side address strobe, active low |
| vpa_n | input | 1 | Slow-device or autovector request, active low |
| e_clk | output | 1 | Regenerated peripheral enable clock |
| vma_n | output | 1 | Valid-address strobe aligned to `e_clk`, active low |
| cyc_done | output | 1 | One-clock transfer-complete pulse toward the processor |

## Verification
The bench builds the block with E_PERIOD = 10, E_HIGH = 4 and REQ_STAGES = 1. These values make the input latency and the 6/4 phase split visible, and they let requests be placed at chosen phases of E. Requests launched at phases 0, 3, 8 and 9 cover two cases. In one, the request lands exactly on the edge that starts an E-low phase, so the strobe is issued at once. In the other, the request has just missed that edge and waits almost a full period. Dropping the address strobe before and during the strobe, sending the request signal alone, and holding the strobe low after completion cover the abandon, the ignore and the re-arm paths.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

  typedef enum logic [1:0] {
    XS_IDLE    = 2'd0,
    XS_ARMED   = 2'd1,
    XS_ACTIVE  = 2'd2,
    XS_RELEASE = 2'd3
  } xfer_state_t;

  // Next value of a modulo-period phase counter.
  function automatic int unsigned phase_advance(input int unsigned phase,
                                                input int unsigned period);
    if (phase + 1 >= period) return 0;
    return phase + 1;
  endfunction

  // Enable clock level for a given phase: low for the first low_len phases.
  function automatic logic e_level(input int unsigned phase,
                                   input int unsigned low_len);
    return (phase >= low_len);
  endfunction

  // True when the phase is the last one of the period (next edge starts E-low).
  function automatic logic phase_is_last(input int unsigned phase,
                                         input int unsigned period);
    return (phase == period - 1);
  endfunction

endpackage

// File: rtl/eclk_phase_gen.sv
module eclk_phase_gen
  import ebus_pkg::*;
#(
  parameter int unsigned E_PERIOD = 10,
  parameter int unsigned E_HIGH   = 4
) (
  input  logic clk,
  input  logic rst,
  output logic e_o,
  output logic wrap_o
);

  localparam int unsigned PW      = (E_PERIOD > 2) ? $clog2(E_PERIOD) : 1;
  localparam int unsigned LOW_LEN = E_PERIOD - E_HIGH;

  logic [PW-1:0] phase_q;
  logic [PW-1:0] phase_d;
  logic          e_q;

  initial begin
    if (E_HIGH == 0 || E_HIGH >= E_PERIOD)
      $error("eclk_phase_gen: E_HIGH must lie between 1 and E_PERIOD-1");
  end

  always_comb begin
    phase_d = PW'(phase_advance(32'(phase_q), E_PERIOD));
  end

  // The enable level is registered from the next phase, so E is a clean flop output.
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      phase_q <= '0;
      e_q     <= 1'b0;
    end else begin
      phase_q <= phase_d;
      e_q     <= e_level(32'(phase_d), LOW_LEN);
    end
  end

  assign e_o    = e_q;
  // The coming edge wraps the counter: it is a falling edge of E.
  assign wrap_o = phase_is_last(32'(phase_q), E_PERIOD);

endmodule

// File: rtl/req_sampler.sv
module req_sampler #(
  parameter int unsigned REQ_STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic as_n,
  input  logic vpa_n,
  output logic req_hit_o,
  output logic as_idle_o
);

  logic as_s;
  logic vpa_s;

  generate
    if (REQ_STAGES == 0) begin : g_pass
      assign as_s  = as_n;
      assign vpa_s = vpa_n;
    end else begin : g_reg
      logic [REQ_STAGES-1:0] as_sh;
      logic [REQ_STAGES-1:0] vpa_sh;

      always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
          as_sh  <= '1;
          vpa_sh <= '1;
        end else begin
          as_sh[0]  <= as_n;
          vpa_sh[0] <= vpa_n;
          for (int i = 1; i < REQ_STAGES; i++) begin
            as_sh[i]  <= as_sh[i-1];
            vpa_sh[i] <= vpa_sh[i-1];
          end
        end
      end

      assign as_s  = as_sh[REQ_STAGES-1];
      assign vpa_s = vpa_sh[REQ_STAGES-1];
    end
  endgenerate

  assign req_hit_o = !as_s && !vpa_s;
  assign as_idle_o = as_s;

endmodule

// File: rtl/vma_xfer_ctrl.sv
module vma_xfer_ctrl
  import ebus_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wrap_i,
  input  logic req_hit_i,
  input  logic as_idle_i,
  output logic vma_n_o,
  output logic done_o
);

  xfer_state_t st_q;
  xfer_state_t st_d;
  logic        done_d;
  logic        vma_n_q;
  logic        done_q;

  always_comb begin
    st_d   = st_q;
    done_d = 1'b0;
    unique case (st_q)
      XS_IDLE: begin
        if (req_hit_i) st_d = wrap_i ? XS_ACTIVE : XS_ARMED;
      end
      XS_ARMED: begin
        // A negated strobe wins over the phase edge: the request is dropped.
        if (as_idle_i)   st_d = XS_IDLE;
        else if (wrap_i) st_d = XS_ACTIVE;
      end
      XS_ACTIVE: begin
        // The strobe is ignored here; the transfer always spans one E period.
        if (wrap_i) begin
          st_d   = XS_RELEASE;
          done_d = 1'b1;
        end
      end
      XS_RELEASE: begin
        if (as_idle_i) st_d = XS_IDLE;
      end
      default: st_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      st_q    <= XS_IDLE;
      vma_n_q <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      vma_n_q <= (st_d != XS_ACTIVE);
      done_q  <= done_d;
    end
  end

  assign vma_n_o = vma_n_q;
  assign done_o  = done_q;

endmodule

// File: rtl/periph_eclk_gen.sv
module periph_eclk_gen #(
  parameter int unsigned E_PERIOD   = 10,
  parameter int unsigned E_HIGH     = 4,
  parameter int unsigned REQ_STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic as_n,
  input  logic vpa_n,
  output logic e_clk,
  output logic vma_n,
  output logic cyc_done
);

  // Named internal events, also seen by the bound checker.
  logic wrap_w;
  logic req_hit_w;
  logic as_idle_w;

  eclk_phase_gen #(
    .E_PERIOD (E_PERIOD),
    .E_HIGH   (E_HIGH)
  ) u_phase (
    .clk    (clk),
    .rst    (rst),
    .e_o    (e_clk),
    .wrap_o (wrap_w)
  );

  req_sampler #(
    .REQ_STAGES (REQ_STAGES)
  ) u_req (
    .clk       (clk),
    .rst       (rst),
    .as_n      (as_n),
    .vpa_n     (vpa_n),
    .req_hit_o (req_hit_w),
    .as_idle_o (as_idle_w)
  );

  vma_xfer_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wrap_i    (wrap_w),
    .req_hit_i (req_hit_w),
    .as_idle_i (as_idle_w),
    .vma_n_o   (vma_n),
    .done_o    (cyc_done)
  );

endmodule

// File: rtl/periph_eclk_chk.sv
module periph_eclk_chk #(
  parameter int unsigned E_PERIOD = 10,
  parameter int unsigned E_HIGH   = 4
) (
  input logic clk,
  input logic rst,
  input logic e,
  input logic vma_n,
  input logic done,
  input logic as_idle
);

  localparam int unsigned RW = $clog2(E_PERIOD + 1) + 1;

  logic          e_prev;
  logic [RW-1:0] run;
  logic          seen_fall;

  // Length of the current E segment, measured independently of the counter.
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      e_prev    <= 1'b0;
      run       <= '0;
      seen_fall <= 1'b0;
    end else begin
      e_prev <= e;
      if (e != e_prev)     run <= RW'(1);
      else if (run != '1)  run <= run + RW'(1);
      if (e_prev && !e)    seen_fall <= 1'b1;
    end
  end

  assert_e_high_len_R1: assert property (@(posedge clk) disable iff (rst)
    (e_prev && !e) |-> (run == RW'(E_HIGH)))
    else $error("E high segment length wrong");

  assert_e_low_len_R1: assert property (@(posedge clk) disable iff (rst)
    (seen_fall && !e_prev && e) |-> (run == RW'(E_PERIOD - E_HIGH)))
    else $error("E low segment length wrong");

  assert_vma_on_e_fall_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(vma_n) |-> $fell(e))
    else $error("VMA asserted away from an E falling edge");

  assert_vma_release_done_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(vma_n) |-> (done && $fell(e)))
    else $error("VMA released without done on an E fall");

  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done)
    else $error("done lasted more than one clock");

  assert_no_vma_after_drop_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(vma_n) |-> $past(!as_idle))
    else $error("VMA issued although the strobe had negated");

endmodule

bind periph_eclk_gen periph_eclk_chk #(
  .E_PERIOD (E_PERIOD),
  .E_HIGH   (E_HIGH)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .e       (e_clk),
  .vma_n   (vma_n),
  .done    (cyc_done),
  .as_idle (as_idle_w)
);

// File: tb/sim_periph_eclk_gen.sv
module sim_periph_eclk_gen;

  localparam int CLK_PERIOD = 10;
  localparam int P  = 10;
  localparam int HI = 4;
  localparam int L  = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic as_n = 1'b1;
  logic vpa_n = 1'b1;
  logic e_clk, vma_n, cyc_done;

  int n = 0;
  int checks = 0;
  int errors = 0;
  int exp_q[$];
  int act_start = -1000;
  int vma_starts = 0;
  int done_seen = 0;
  logic vma_prev = 1'b1;
  logic done_prev = 1'b0;
  bit finished = 0;

  periph_eclk_gen #(.E_PERIOD(P), .E_HIGH(HI), .REQ_STAGES(L)) u0 (
    .clk(clk), .rst(rst), .as_n(as_n), .vpa_n(vpa_n),
    .e_clk(e_clk), .vma_n(vma_n), .cyc_done(cyc_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) n <= 0;
    else     n <= n + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (edge %0d)", tag, act, expv, n);
    end
  endtask

  function automatic int next_start(input int x);
    return ((x + P - 1) / P) * P;
  endfunction

  // Monitor: scoreboard pop and compare, plus the E waveform.
  always @(negedge clk) begin
    if (!rst) begin
      check(e_clk == ((n % P) >= (P - HI)), "R1 e_clk level", e_clk, ((n % P) >= (P - HI)));
      if (!vma_n && vma_prev) begin
        vma_starts++;
        if (exp_q.size() == 0) begin
          check(0, "R4 unexpected vma_n assertion", n, -1);
        end else begin
          int m;
          m = exp_q.pop_front();
          check(n == m, "R4 vma_n assertion edge", n, m);
        end
        act_start = n;
      end
      if (vma_n && !vma_prev)
        check(n == act_start + P, "R5 vma_n release edge", n, act_start + P);
      if (cyc_done) begin
        done_seen++;
        check(n == act_start + P, "R5 cyc_done edge", n, act_start + P);
        check(!done_prev, "R5 cyc_done single clock", done_prev, 0);
      end
      vma_prev  = vma_n;
      done_prev = cyc_done;
    end
  end

  task automatic wait_phase(input int ph);
    do @(negedge clk); while ((n % P) != ph);
  endtask

  task automatic run_access(input int ph, input bit drop_mid, input bit hold_after);
    wait_phase(ph);
    as_n = 1'b0; vpa_n = 1'b0;
    exp_q.push_back(next_start(n + 1 + L));
    if (drop_mid) begin
      do @(negedge clk); while (vma_n);
      repeat (3) @(negedge clk);
      as_n = 1'b1; vpa_n = 1'b1;   // R7: release while strobe is active
    end
    do @(negedge clk); while (!cyc_done);
    if (hold_after) begin
      int s;
      s = vma_starts;
      repeat (3 * P) @(negedge clk);
      check(vma_starts == s, "R8 no restart while as_n held low", vma_starts - s, 0);
      check(vma_n == 1'b1, "R8 vma_n idle while as_n held low", vma_n, 1);
    end
    as_n = 1'b1; vpa_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(e_clk == 1'b0, "R9 reset e_clk", e_clk, 0);
    check(vma_n == 1'b1, "R9 reset vma_n", vma_n, 1);
    check(cyc_done == 1'b0, "R9 reset cyc_done", cyc_done, 0);
    rst = 1'b0;

    // R2: free-running E with no activity
    begin
      int rises;
      logic ep;
      rises = 0;
      @(negedge clk);
      ep = e_clk;
      repeat (10 * P) begin
        @(negedge clk);
        if (e_clk && !ep) rises++;
        ep = e_clk;
      end
      check(rises == 10, "R2 idle E rising edges", rises, 10);
    end

    // R4: request at several phases, including on and just after the low-phase start
    run_access(0, 0, 0);
    run_access(3, 0, 0);
    run_access(8, 0, 0);
    run_access(9, 0, 0);
    run_access(5, 0, 0);

    // R7: strobe negated mid-transfer, full period still expected
    run_access(2, 1, 0);

    // R6: strobe negated before VMA
    begin
      int s, d;
      s = vma_starts; d = done_seen;
      wait_phase(1);
      as_n = 1'b0; vpa_n = 1'b0;
      repeat (2) @(negedge clk);
      as_n = 1'b1; vpa_n = 1'b1;
      repeat (3 * P) @(negedge clk);
      check(vma_starts == s, "R6 abandoned request gives no vma_n", vma_starts - s, 0);
      check(done_seen == d, "R6 abandoned request gives no cyc_done", done_seen - d, 0);
    end

    // R3: request line alone, strobe alone
    begin
      int s;
      s = vma_starts;
      vpa_n = 1'b0;
      repeat (3 * P) @(negedge clk);
      vpa_n = 1'b1;
      check(vma_starts == s, "R3 vpa_n alone ignored", vma_starts - s, 0);
      as_n = 1'b0;
      repeat (3 * P) @(negedge clk);
      as_n = 1'b1;
      check(vma_starts == s, "R3 as_n alone ignored", vma_starts - s, 0);
      check(vma_n == 1'b1, "R3 vma_n idle", vma_n, 1);
    end

    // R8: hold strobe after completion, then recover
    run_access(4, 0, 1);
    run_access(7, 0, 0);

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R4 all expected transfers seen", exp_q.size(), 0);
    check(done_seen == 8, "R5 completion count", done_seen, 8);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule